// File: doc/BRIEF.md
# Mixed-Ratio Reference Clock Divider

This block divides a reference clock by one of sixteen ratios chosen by a 4-bit select code. The lower half of the code space gives powers of two. The upper half gives a set of ratios built on five, plus one ratio of 24. It produces two outputs. The first is a registered divided clock whose period equals the selected ratio. The second is a one-cycle terminal-count pulse that marks the last input cycle of each output period, for use as a comparison-rate enable.

A new code is captured only while the load strobe is high. The captured code is applied at the next terminal count, so the period already running always completes at its old length and no short or long output cycle appears. Inside, a down-counter runs from ratio minus one to zero. A two-state phase machine has the states `PH_LOW` and `PH_HIGH`. The transition *rise* (`PH_LOW` to `PH_HIGH`) fires when the remaining count falls below half the ratio. The transition *wrap* (`PH_HIGH` to `PH_LOW`) fires at the terminal count, which is also when the counter reloads. In every other cycle each state holds.

Top module: `mixratio_clkdiv`

## Requirements
- R1: Codes 0 to 7 (binary 0000 to 0111) give output periods of 2, 4, 8, 16, 32, 64, 128 and 256 input cycles respectively.
- R2: Code 8 gives a period of 24. Codes 9 to 15 give 5, 10, 20, 40, 80, 160 and 320 in that order.
- R3: `tc_pulse` is high for exactly one input cycle per output period, in that period's last cycle, so consecutive pulses are spaced by the active ratio.
- R4: Within a period of N cycles, `div_out` is low for the first ceil(N/2) cycles and high for the last floor(N/2), including the terminal cycle. For odd N the high phase is one cycle shorter.
- R5: A code captured by `load_stb` takes effect at the first reload after the capture edge. The period in progress completes at its old length.
- R6: If several strobes occur before one reload, the code from the last strobe is the one applied.
- R7: A strobe sampled on the same edge as a reload is applied at the following reload, one full period later.
- R8: Asynchronous active-low reset forces `div_out` and `tc_pulse` low and selects code 0. The first `tc_pulse` appears after the first rising edge following release, and pulses then repeat every 2 cycles.
- R9: Changes on `ratio_code` while `load_stb` is low do not alter any output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_code | input | 4 | Ratio select code, sampled only with `load_stb` |
| load_stb | input | 1 | Captures `ratio_code` for the next reload |
| div_out | output | 1 | Registered divided clock |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench measures the period and the high time for every code, and it also draws codes at random. A mapping slip, such as treating code 8 as another power of two, would show up as a wrong period. An off-by-one in the phase split would make odd ratios symmetric or put the extra cycle in the wrong phase. Strobes are placed in the middle of a 256-cycle period, stacked twice before one reload, and lined up exactly with the terminal cycle. A design that applied codes at once would produce a runt period, one that latched the first strobe would use a stale ratio, and one with the wrong capture priority would shift the change by a period. The select bus is also toggled with the strobe low, to catch a design that reads the code without the strobe.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int CODE_W    = 4;
    localparam int RATIO_MAX = 320;
    localparam int RATIO_W   = $clog2(RATIO_MAX + 1);

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    // Lower half: 2 << k. Code 8: 24. Codes 9..15: 5 << (k-1).
    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        if (!c[CODE_W-1])
            r = RATIO_W'(2) << c[CODE_W-2:0];
        else if (c[CODE_W-2:0] == '0)
            r = RATIO_W'(24);
        else
            r = RATIO_W'(5) << (c[CODE_W-2:0] - 3'd1);
        return r;
    endfunction

endpackage

// File: rtl/refdiv_ratio_lut.sv
module refdiv_ratio_lut
    import refdiv_pkg::*;
#(
    parameter int SEL_W = CODE_W,
    parameter int CNT_W = RATIO_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] ratio
);
    always_comb begin
        ratio = CNT_W'(code_ratio(CODE_W'(sel)));
    end

    always_comb begin
        if (!$isunknown(sel)) begin
            a_ratio_min_r1: assert (ratio >= CNT_W'(2));
        end
    end
endmodule

// File: rtl/refdiv_code_regs.sv
module refdiv_code_regs
    import refdiv_pkg::*;
#(
    parameter int SEL_W = CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [SEL_W-1:0] code_in,
    input  logic             reload,
    output logic [SEL_W-1:0] pend_code,
    output logic [SEL_W-1:0] active_code
);
    // Pending slot: last strobe wins (R6), ignored without strobe (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_code <= '0;
        else if (load_stb)
            pend_code <= code_in;
    end

    // Active code advances only at a terminal reload (R5, R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            active_code <= '0;
        else if (reload)
            active_code <= pend_code;
    end

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(pend_code));

    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(active_code));
endmodule

// File: rtl/refdiv_phase_fsm.sv
module refdiv_phase_fsm
    import refdiv_pkg::*;
#(
    parameter int CNT_W = RATIO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_ratio,
    input  logic [CNT_W-1:0] active_ratio,
    output logic             reload,
    output logic             div_out,
    output logic             tc_pulse
);
    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(code_ratio('0)) - CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d, half;
    phase_t           st_q, st_d;

    assign half   = active_ratio >> 1;
    assign reload = (cnt_q == '0);

    // Next-state and counter logic
    always_comb begin
        if (reload) begin
            cnt_d = reload_ratio - CNT_W'(1);
            st_d  = PH_LOW;                        // wrap
        end else begin
            cnt_d = cnt_q - CNT_W'(1);
            unique case (st_q)
                PH_LOW:  st_d = (cnt_d < half) ? PH_HIGH : PH_LOW;  // rise
                PH_HIGH: st_d = PH_HIGH;
                default: st_d = PH_LOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_LOW;
            cnt_q <= RST_CNT;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_out  <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            div_out  <= (st_d == PH_HIGH);
            tc_pulse <= (cnt_d == '0);
        end
    end

    p_tc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < active_ratio);

    p_tc_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> div_out);

    p_fall_after_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_out) |-> $past(tc_pulse));
endmodule

// File: rtl/mixratio_clkdiv.sv
module mixratio_clkdiv
    import refdiv_pkg::*;
#(
    parameter int SEL_W = CODE_W,
    parameter int CNT_W = RATIO_W
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_code,
    input  logic             load_stb,
    output logic             div_out,
    output logic             tc_pulse
);
    logic [SEL_W-1:0] pend_code, active_code;
    logic [CNT_W-1:0] reload_ratio, active_ratio;
    logic             reload;

    refdiv_code_regs #(.SEL_W(SEL_W)) u_codes (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .load_stb    (load_stb),
        .code_in     (ratio_code),
        .reload      (reload),
        .pend_code   (pend_code),
        .active_code (active_code)
    );

    refdiv_ratio_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_lut_next (
        .sel   (pend_code),
        .ratio (reload_ratio)
    );

    refdiv_ratio_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_lut_cur (
        .sel   (active_code),
        .ratio (active_ratio)
    );

    refdiv_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk_ref),
        .rst_n        (rst_n),
        .reload_ratio (reload_ratio),
        .active_ratio (active_ratio),
        .reload       (reload),
        .div_out      (div_out),
        .tc_pulse     (tc_pulse)
    );
endmodule

// File: tb/mixratio_clkdiv_test.sv
module mixratio_clkdiv_test;
    logic       clk_ref = 1'b0;
    logic       rst_n;
    logic [3:0] ratio_code;
    logic       load_stb;
    logic       div_out, tc_pulse;

    int n_chk = 0;
    int n_bad = 0;

    mixratio_clkdiv uut (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .load_stb   (load_stb),
        .div_out    (div_out),
        .tc_pulse   (tc_pulse)
    );

    always #5 clk_ref = ~clk_ref;

    function automatic int exp_ratio(input int c);
        case (c)
            0: return 2;    1: return 4;    2: return 8;    3: return 16;
            4: return 32;   5: return 64;   6: return 128;  7: return 256;
            8: return 24;   9: return 5;    10: return 10;  11: return 20;
            12: return 40;  13: return 80;  14: return 160; default: return 320;
        endcase
    endfunction

    function automatic string tag_for(input int c);
        return (c < 8) ? "R1" : "R2";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // From the current window, step until a window shows tc
    task automatic wait_tc();
        while (!tc_pulse) @(negedge clk_ref);
    endtask

    // Count further windows through the next tc; optionally toggle the code bus
    task automatic count_rest(inout int len, inout int hi, input bit wiggle);
        do begin
            if (wiggle) ratio_code = 4'($urandom);
            @(negedge clk_ref);
            len++;
            if (div_out) hi++;
        end while (!tc_pulse);
    endtask

    task automatic strobe(input int c);
        ratio_code = 4'(c);
        load_stb   = 1'b1;
        @(negedge clk_ref);
        load_stb   = 1'b0;
    endtask

    // Program a code outside a tc window, then measure the first full new period
    task automatic apply_and_measure(input int c);
        int len, hi;
        wait_tc();
        @(negedge clk_ref);
        strobe(c);
        ratio_code = 4'($urandom);      // R9: bus noise without strobe
        wait_tc();
        len = 0; hi = 0;
        count_rest(len, hi, 1'b0);
        check(tag_for(c), len, exp_ratio(c));
        check("R4", hi, exp_ratio(c) / 2);
        check("R3", int'(tc_pulse), 1);
    endtask

    initial begin
        int len, hi;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ratio_code = 4'd0; load_stb = 1'b0;
        repeat (3) @(negedge clk_ref);
        // R8: reset state
        check("R8", int'(div_out), 0);
        check("R8", int'(tc_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk_ref);
        check("R8", int'(tc_pulse), 1);
        len = 0; hi = 0;
        count_rest(len, hi, 1'b0);
        check("R8", len, 2);

        // R1 / R2: every code in order
        for (int c = 0; c < 16; c++) apply_and_measure(c);

        // R5: strobe mid-period of a 256 run; running period keeps its length
        apply_and_measure(7);
        len = 0; hi = 0;
        repeat (100) begin @(negedge clk_ref); len++; end
        strobe(9); len++;
        count_rest(len, hi, 1'b0);
        check("R5", len, 256);
        len = 0; hi = 0;
        count_rest(len, hi, 1'b0);
        check("R5", len, 5);
        check("R4", hi, 2);

        // R6: two strobes before one reload, last wins
        apply_and_measure(7);
        @(negedge clk_ref);
        strobe(3);
        repeat (10) @(negedge clk_ref);
        strobe(12);
        wait_tc();
        len = 0; hi = 0;
        count_rest(len, hi, 1'b0);
        check("R6", len, 40);

        // R7: strobe sampled on the reload edge applies one period later
        apply_and_measure(11);
        ratio_code = 4'd9; load_stb = 1'b1;      // in the tc window
        @(negedge clk_ref);
        load_stb = 1'b0;
        len = 1; hi = div_out ? 1 : 0;
        count_rest(len, hi, 1'b0);
        check("R7", len, 20);
        len = 0; hi = 0;
        count_rest(len, hi, 1'b0);
        check("R7", len, 5);

        // R9: bus toggled every cycle, no strobe
        apply_and_measure(10);
        for (int k = 0; k < 3; k++) begin
            len = 0; hi = 0;
            count_rest(len, hi, 1'b1);
            check("R9", len, 10);
        end

        // Random codes
        for (int k = 0; k < 40; k++) apply_and_measure(int'($urandom_range(15, 0)));

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_ref);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule